// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block is a one-bit-wide configuration store that a master-serial programmable-logic loader reads one bit per clock. Reading always starts at address zero and walks upward. A single control pin carries two meanings: one level restarts the read sequence, and the other level enables the read. A configuration bit selects which level does which. An active-low chip enable qualifies both counting and driving. The data output comes with a separate enable flag that stands for the tri-state driver.

When the last location has been clocked out, the block releases its data output and pulls its active-low chain-enable output low. That output feeds the chip enable of the next reader, so several readers connected in a chain deliver one continuous stream. A serial-enable input selects between read mode and programming mode. In programming mode the read path is idle and a simple one-bit-per-cycle write port fills the array.

The array depth is a parameter. It defaults to a small size for elaboration and can be set to 1,048,576 for a full one-megabit image. A synchronous active-high power-up reset clears the counters, and a ready flag rises one clock after that reset is released.

Top module: `cfgrom_reader`

## Requirements
- R1: While `rst` is high, `ready` is 0, `dout_oe` is 0 and `ceo_n` is 1. `ready` becomes 1 on the first rising edge with `rst` low. No bit is driven or counted before `ready` is 1.
- R2: In read mode (`ser_en`=1, `ce_n`=0, control pin at its enable level, `ready`=1), `dout_oe` is 1 and `dout` shows the stored bit at the current address. Reading starts at address 0, and each rising edge moves the address up by one.
- R3: While `ce_n` is 1, `dout_oe` is 0 and the address holds. When `ce_n` returns to 0, output resumes at the same bit.
- R4: At its restart level, the control pin forces `dout_oe` to 0 at once, whatever `ce_n` is. It also clears the address to 0 at the next rising edge, so the next bit read is bit 0.
- R5: After the bit at address DEPTH-1 is clocked out, `dout_oe` is 0 and `ceo_n` is 0. Further clocks neither wrap the address nor drive data.
- R6: Once exhausted, `ceo_n` equals `ce_n` while the control pin is at its enable level. It goes to 1 as soon as the pin moves to its restart level. It then stays 1 until all DEPTH bits have been read again.
- R7: With `pol_sel`=0, pin level 1 enables and level 0 restarts. With `pol_sel`=1, level 0 enables and level 1 restarts.
- R8: With `ser_en`=0, `dout_oe` is 0 and `ceo_n` is 1 whatever `ce_n` does, and the address is held at 0. With `wr_en`=1, the array location at `wr_addr` takes `wr_bit` at the rising edge. Read mode resumes one rising edge after `ser_en` returns to 1.
- R9: With `ser_en`=1, `wr_en` has no effect on the array.
- R10: When two readers are chained (the first reader's `ceo_n` drives the second reader's `ce_n`), exactly one of them drives in each cycle. The combined stream is all DEPTH bits of the first reader followed by all DEPTH bits of the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial read clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| ctl_pin | input | 1 | Combined restart / output-enable pin |
| pol_sel | input | 1 | Polarity of ctl_pin: 0 = high enables, 1 = low enables |
| ce_n | input | 1 | Active-low chip enable |
| ser_en | input | 1 | 1 = read mode, 0 = programming mode |
| wr_en | input | 1 | Preload write strobe, honoured in programming mode only |
| wr_addr | input | ADDR_W | Preload write address |
| wr_bit | input | 1 | Preload write data |
| dout | output | 1 | Serial data bit (0 when not driven) |
| dout_oe | output | 1 | Output driver enable for dout |
| ceo_n | output | 1 | Active-low chain enable for the next reader |
| ready | output | 1 | High once power-up reset has completed |

## Verification
Changes on `ce_n`, the control pin and `ser_en` reach `dout_oe`, `dout` and `ceo_n` in the same cycle. An address step shows up on `dout` only after the next rising edge. `ready` and the step out of programming mode each need exactly one rising edge. The bench therefore changes inputs 2 ns after a rising edge and samples 1 ns later. Each expected value is tied to the number of edges counted since the last restart or mode change. The full chained read is compared bit by bit against a pattern function computed in the bench.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

    // Read-sequence phase of one reader
    typedef enum logic [1:0] {
        PH_PROG = 2'd0,   // programming mode, read path idle
        PH_READ = 2'd1,   // counting through the array
        PH_DONE = 2'd2    // array exhausted, chain handed on
    } phase_e;

    // Decoded control lines
    typedef struct packed {
        logic oe_act;     // control pin at its enable level
        logic clr;        // control pin at its restart level in read mode
        logic drive;      // all read qualifiers present
    } ctl_s;

    // Map the combined control pin to "enable" according to polarity
    function automatic logic pin_is_enable(input logic pin, input logic pol);
        return pol ? ~pin : pin;
    endfunction

    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/cfgrom_ctl_decode.sv
module cfgrom_ctl_decode
    import cfgrom_pkg::*;
(
    input  logic ctl_pin,
    input  logic pol_sel,
    input  logic ce_n,
    input  logic ser_en,
    input  logic ready,
    output ctl_s ctl
);
    logic oe_lvl;

    always_comb begin
        oe_lvl     = pin_is_enable(ctl_pin, pol_sel);
        ctl.oe_act = oe_lvl;
        ctl.clr    = ser_en & ~oe_lvl;
        ctl.drive  = ser_en & ~ce_n & oe_lvl & ready;
    end
endmodule

// File: rtl/cfgrom_seq.sv
module cfgrom_seq
    import cfgrom_pkg::*;
#(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned ADDR_W = addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_en,
    input  ctl_s              ctl,
    output logic [ADDR_W-1:0] addr_q,
    output phase_e            phase_q
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    logic advance;

    assign advance = ctl.drive && (phase_q == PH_READ);

    always_ff @(posedge clk) begin
        if (rst || !ser_en || ctl.clr) begin
            addr_q  <= '0;
            phase_q <= ser_en ? PH_READ : PH_PROG;
        end else if (phase_q == PH_PROG) begin
            // leaving programming mode: start fresh at address zero
            addr_q  <= '0;
            phase_q <= PH_READ;
        end else if (advance) begin
            if (addr_q == LAST_ADDR) begin
                phase_q <= PH_DONE;        // saturate, never wrap
            end else begin
                addr_q  <= addr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgrom_store.sv
module cfgrom_store #(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bit
);
    logic mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_addr) < DEPTH)) begin
            mem[wr_addr] <= wr_bit;
        end
    end

    assign rd_bit = mem[rd_addr];
endmodule

// File: rtl/cfgrom_reader.sv
module cfgrom_reader
    import cfgrom_pkg::*;
#(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned ADDR_W = addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_pin,
    input  logic              pol_sel,
    input  logic              ce_n,
    input  logic              ser_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    output logic              dout,
    output logic              dout_oe,
    output logic              ceo_n,
    output logic              ready
);
    ctl_s              ctl;
    logic [ADDR_W-1:0] addr_q;
    phase_e            phase_q;
    logic              rd_bit;
    logic              ready_q;
    logic              at_end;

    always_ff @(posedge clk) begin
        ready_q <= ~rst;
    end
    assign ready = ready_q;

    cfgrom_ctl_decode u_decode (
        .ctl_pin (ctl_pin),
        .pol_sel (pol_sel),
        .ce_n    (ce_n),
        .ser_en  (ser_en),
        .ready   (ready_q),
        .ctl     (ctl)
    );

    cfgrom_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .ser_en  (ser_en),
        .ctl     (ctl),
        .addr_q  (addr_q),
        .phase_q (phase_q)
    );

    cfgrom_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en & ~ser_en),
        .wr_addr (wr_addr),
        .wr_bit  (wr_bit),
        .rd_addr (addr_q),
        .rd_bit  (rd_bit)
    );

    assign at_end  = (phase_q == PH_DONE);
    assign dout_oe = ctl.drive && (phase_q == PH_READ) && !rst;
    assign dout    = dout_oe & rd_bit;
    // chain enable: low only when exhausted, pin enabling, and own enable low
    assign ceo_n   = ce_n | ~(at_end & ser_en & ctl.oe_act & ~rst);
endmodule

// File: rtl/cfgrom_reader_chk.sv
module cfgrom_reader_chk #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_pin,
    input logic              pol_sel,
    input logic              ce_n,
    input logic              ser_en,
    input logic              dout_oe,
    input logic              ceo_n,
    input logic              ready,
    input logic [ADDR_W-1:0] addr,
    input logic              done
);
    logic oe_lvl;
    assign oe_lvl = pol_sel ? !ctl_pin : ctl_pin;

    p_ready_rise_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ready);

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        dout_oe |=> (addr == $past(addr) + 1'b1) || done);

    p_drive_needs_ce_r3: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> (!ce_n && ser_en));

    p_hold_ce_high_r3: assert property (@(posedge clk) disable iff (rst)
        (ce_n && ser_en && oe_lvl && ready) |=> $stable(addr));

    p_pin_clear_r4_r7: assert property (@(posedge clk) disable iff (rst)
        (ser_en && !oe_lvl) |=> ((addr == '0) && !done));

    p_quiet_done_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !dout_oe);

    p_ceo_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !done |-> ceo_n);

    p_prog_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !ser_en |-> (!dout_oe && ceo_n));
endmodule

bind cfgrom_reader cfgrom_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctl_pin (ctl_pin),
    .pol_sel (pol_sel),
    .ce_n    (ce_n),
    .ser_en  (ser_en),
    .dout_oe (dout_oe),
    .ceo_n   (ceo_n),
    .ready   (ready),
    .addr    (addr_q),
    .done    (at_end)
);

// File: tb/cfgrom_reader_bench.sv
module cfgrom_reader_bench;
    localparam int unsigned DEPTH  = 16;
    localparam int unsigned ADDR_W = 4;

    logic clk = 1'b0;
    logic rst, ctl_pin, pol_sel, ce_n_a, ser_en;
    logic wr_en_a, wr_en_b, wr_bit;
    logic [ADDR_W-1:0] wr_addr;
    logic dout_a, oe_a, ceo_a, rdy_a;
    logic dout_b, oe_b, ceo_b, rdy_b;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cfgrom_reader #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cfgrom_reader (
        .clk(clk), .rst(rst), .ctl_pin(ctl_pin), .pol_sel(pol_sel),
        .ce_n(ce_n_a), .ser_en(ser_en), .wr_en(wr_en_a), .wr_addr(wr_addr),
        .wr_bit(wr_bit), .dout(dout_a), .dout_oe(oe_a), .ceo_n(ceo_a),
        .ready(rdy_a)
    );

    cfgrom_reader #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cfgrom_reader_nxt (
        .clk(clk), .rst(rst), .ctl_pin(ctl_pin), .pol_sel(pol_sel),
        .ce_n(ceo_a), .ser_en(ser_en), .wr_en(wr_en_b), .wr_addr(wr_addr),
        .wr_bit(wr_bit), .dout(dout_b), .dout_oe(oe_b), .ceo_n(ceo_b),
        .ready(rdy_b)
    );

    function automatic logic pat(input int s, input int i);
        return 1'(((i * 13 + s * 7) >> 2) ^ i);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // move to 2 ns after the next rising edge
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic restart_pin();
        ctl_pin = pol_sel;   // restart level
        tick();
        ctl_pin = ~pol_sel;  // enable level
        settle();
    endtask

    task automatic t_reset();
        rst = 1'b1; ser_en = 1'b1; ctl_pin = 1'b1; pol_sel = 1'b0; ce_n_a = 1'b0;
        wr_en_a = 1'b0; wr_en_b = 1'b0; wr_addr = '0; wr_bit = 1'b0;
        tick(); tick();
        settle();
        chk("R1 ready in reset", 32'(rdy_a), 32'd0);
        chk("R1 oe in reset", 32'(oe_a), 32'd0);
        chk("R1 ceo in reset", 32'(ceo_a), 32'd1);
        rst = 1'b0;
        tick();
        settle();
        chk("R1 ready after release", 32'(rdy_a), 32'd1);
    endtask

    task automatic t_load();
        ser_en = 1'b0;
        settle();
        chk("R8 no drive in prog", 32'(oe_a), 32'd0);
        chk("R8 ceo high in prog", 32'(ceo_a), 32'd1);
        for (int i = 0; i < int'(DEPTH); i++) begin
            wr_en_a = 1'b1; wr_en_b = 1'b0; wr_addr = ADDR_W'(i); wr_bit = pat(1, i);
            tick();
            wr_en_a = 1'b0; wr_en_b = 1'b1; wr_bit = pat(2, i);
            tick();
        end
        wr_en_b = 1'b0;
        chk("R8 ce ignored in prog", 32'(oe_a), 32'd0);
        ser_en = 1'b1;
        tick();   // programming -> read
        settle();
    endtask

    task automatic t_chain_read();
        int errs = 0;
        for (int k = 0; k < 2 * int'(DEPTH); k++) begin
            logic exp_bit;
            logic got;
            exp_bit = (k < int'(DEPTH)) ? pat(1, k) : pat(2, k - int'(DEPTH));
            got = oe_a ? dout_a : dout_b;
            checks++;
            if ((32'(oe_a) + 32'(oe_b)) != 32'd1 || got !== exp_bit) begin
                errs++; failures++;
                $display("FAIL R2/R10 bit %0d actual=%0b expected=%0b oe=%0b%0b",
                         k, got, exp_bit, oe_a, oe_b);
            end
            if (k == int'(DEPTH)) begin
                chk("R5 handoff ceo low", 32'(ceo_a), 32'd0);
                chk("R10 first reader released", 32'(oe_a), 32'd0);
            end
            tick();
            settle();
        end
        chk("R5 first exhausted", 32'(oe_a), 32'd0);
        chk("R10 second exhausted ceo", 32'(ceo_b), 32'd0);
        tick(); tick(); tick();
        settle();
        chk("R5 no wrap first", 32'(oe_a), 32'd0);
        chk("R5 no wrap second", 32'(oe_b), 32'd0);
        chk("R5 ceo stays low", 32'(ceo_a), 32'd0);
    endtask

    task automatic t_ceo_follow();
        ce_n_a = 1'b1; settle();
        chk("R6 ceo follows ce high", 32'(ceo_a), 32'd1);
        ce_n_a = 1'b0; settle();
        chk("R6 ceo follows ce low", 32'(ceo_a), 32'd0);
        ctl_pin = 1'b0; settle();
        chk("R6 ceo high on restart level", 32'(ceo_a), 32'd1);
        tick();
        ctl_pin = 1'b1; settle();
        chk("R6 ceo stays high after restart", 32'(ceo_a), 32'd1);
        chk("R4 restart gives bit0", {30'd0, oe_a, dout_a}, {30'd0, 1'b1, pat(1, 0)});
        for (int i = 0; i < int'(DEPTH) - 1; i++) tick();
        settle();
        chk("R6 ceo high until last bit", 32'(ceo_a), 32'd1);
        tick(); settle();
        chk("R6 ceo low after full reread", 32'(ceo_a), 32'd0);
    endtask

    task automatic t_ce_pause();
        restart_pin();
        tick(); tick(); tick();
        ce_n_a = 1'b1; settle();
        chk("R3 no drive with ce high", 32'(oe_a), 32'd0);
        tick(); tick(); tick();
        ce_n_a = 1'b0; settle();
        chk("R3 resume at bit3", {30'd0, oe_a, dout_a}, {30'd0, 1'b1, pat(1, 3)});
    endtask

    task automatic t_pin_reset();
        tick(); tick();
        ce_n_a = 1'b1; ctl_pin = 1'b0; settle();
        chk("R4 no drive at restart level", 32'(oe_a), 32'd0);
        tick();
        ctl_pin = 1'b1; ce_n_a = 1'b0; settle();
        chk("R4 restart with ce high gives bit0", {30'd0, oe_a, dout_a},
            {30'd0, 1'b1, pat(1, 0)});
    endtask

    task automatic t_polarity();
        tick(); tick();
        pol_sel = 1'b1; ctl_pin = 1'b1; settle();
        chk("R7 inverted: high restarts", 32'(oe_a), 32'd0);
        tick();
        ctl_pin = 1'b0; settle();
        chk("R7 inverted: low enables bit0", {30'd0, oe_a, dout_a},
            {30'd0, 1'b1, pat(1, 0)});
        tick(); settle();
        chk("R7 inverted: bit1", {30'd0, oe_a, dout_a}, {30'd0, 1'b1, pat(1, 1)});
        pol_sel = 1'b0; ctl_pin = 1'b1;
        settle();
    endtask

    task automatic t_write_ignored();
        restart_pin();
        wr_en_a = 1'b1; wr_addr = '0; wr_bit = ~pat(1, 0);
        tick();
        wr_en_a = 1'b0;
        restart_pin();
        chk("R9 write ignored in read mode", {30'd0, oe_a, dout_a},
            {30'd0, 1'b1, pat(1, 0)});
    endtask

    initial begin
        t_reset();
        t_load();
        t_chain_read();
        t_ceo_follow();
        t_ce_pause();
        t_pin_reset();
        t_polarity();
        t_write_ignored();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule